// File: doc/BRIEF.md
# Control Register Write Side-Effect Unit

This block owns the paging and mode control registers of a processor core together with the segment base registers, and applies the side effects that a write to any of them must cause. Every write is compared bit by bit against the value it replaces. From the bits that changed, the block decides four things:

- whether long mode becomes active or inactive;
- which class of translation-cache flush to request;
- whether the effective segment bases must be rebuilt;
- whether the downstream mode decoder must recompute its mode word.

Software-visible state is written through a single write port (enable, address, data). A combinational read port returns any stored or effective value. Flush requests go to the instruction and data translation caches as one-cycle pulses in the cycle after the write. The mode decoder gets a one-cycle recompute strobe in that same cycle.

Address map (5-bit address):

| Address | Register | Access |
|---|---|---|
| 0 | paging control word (CR0) | read/write |
| 1 | page-table root (CR3) | read/write |
| 2 | paging feature word (CR4) | read/write |
| 3 | extended feature word (EFER) | read/write |
| 4 | code-segment attributes | read/write |
| 5 | stack-segment attributes | read/write |
| 8 to 15 | stored bases of segments 0..7 | read/write |
| 16 to 23 | effective bases of segments 0..7 | read-only |
| anything else | unused | reads zero |

Segments 0..7 are ES, CS, SS, DS, FS, GS, TR and IDTR, in that order.

Bit positions used by the block:

| Register | Bit | Meaning |
|---|---|---|
| CR0 | 31 | paging enable |
| CR0 | 4 | ET |
| CR4 | 4 | PSE |
| CR4 | 5 | PAE |
| CR4 | 7 | PGE |
| EFER | 8 | long-mode enable |
| EFER | 10 | long-mode active |
| code-segment attributes | 0 | 64-bit code flag |

Top module: `cr_side_effect_unit`

## Requirements
- R1: When a CR0 write changes bit 31 and EFER bit 8 is set, EFER bit 10 takes the new value of CR0 bit 31. Otherwise a CR0 write leaves EFER unchanged. `efer_lma` always mirrors EFER bit 10.
- R2: A CR0 write that changes bit 31 raises `itlb_flush_all` and `dtlb_flush_all` for exactly the next cycle. A CR0 write that leaves bit 31 unchanged raises neither.
- R3: Every write to CR3 raises `itlb_flush_nonglobal` and `dtlb_flush_nonglobal` for exactly the next cycle, even when the value written equals the old one.
- R4: A CR4 write that changes any of bits 4, 5 or 7 raises both flush-all outputs for the next cycle. Changes confined to other CR4 bits raise no flush.
- R5: CR0 bit 4 reads as 1 after reset and after every CR0 write, whatever was written to it.
- R6: When a write changes bit 0 of the code-segment attributes to 1, the effective bases of segments 0..3 become zero. When a write changes it to 0, those four effective bases are reloaded from their stored bases. Writes that leave bit 0 unchanged touch no effective base.
- R7: A write to the stored base of segment 4, 5, 6 or 7 copies the value into that segment's effective base.
- R8: A write to the stored base of segment 0..3 always updates the stored base. It also updates the matching effective base, unless EFER bit 10 and code-segment attribute bit 0 are both set; in that case the effective base keeps its value.
- R9: Writes to CR0, the code-segment attributes or the stack-segment attributes raise `mode_recompute` for exactly the next cycle. Writes to any other address never raise it.
- R10: After reset, every register reads zero except CR0, which reads 0x10. Writes to addresses 16..23 or to unused addresses change no state. A written value becomes readable in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 64 | Combinational read data |
| itlb_flush_all | output | 1 | Instruction translation cache: flush all entries |
| itlb_flush_nonglobal | output | 1 | Instruction translation cache: flush non-global entries |
| dtlb_flush_all | output | 1 | Data translation cache: flush all entries |
| dtlb_flush_nonglobal | output | 1 | Data translation cache: flush non-global entries |
| mode_recompute | output | 1 | Strobe to the mode decoder |
| efer_lma | output | 1 | Long-mode-active bit |

## Verification
The bench targets the following corner cases.

- **Paging toggle without long-mode enable.** This must flush but leave long mode inactive. A design that gates the flush on long-mode enable would miss the flush.
- **CR0 rewrite with bit 31 unchanged.** A design that flushes on any CR0 write would emit a spurious pulse.
- **CR3 rewrite with an identical value.** A design that applies a change test to CR3 would drop the non-global flush.
- **CR4 changes outside bits 4, 5 and 7.** An over-broad mask would flush here.
- **Legacy base writes while 64-bit code is active.** These must leave the effective base alone, and a later drop of the 64-bit flag must restore the stored bases. A design that reloads from stale state, or always copies, would show the wrong effective base.
- **Writes to the read-only effective-base addresses.** A design that decodes these as writes would corrupt state.

// File: rtl/cr_pkg.sv
package cr_pkg;
  // Register addresses
  localparam int A_CR0     = 0;
  localparam int A_CR3     = 1;
  localparam int A_CR4     = 2;
  localparam int A_EFER    = 3;
  localparam int A_CSATTR  = 4;
  localparam int A_SSATTR  = 5;
  localparam int A_BASE0   = 8;
  localparam int A_EFF0    = 16;

  // Bit positions
  localparam int B_PG      = 31;
  localparam int B_ET      = 4;
  localparam int B_LME     = 8;
  localparam int B_LMA     = 10;
  localparam int B_PSE     = 4;
  localparam int B_PAE     = 5;
  localparam int B_PGE     = 7;
  localparam int B_CS_LM   = 0;
endpackage

// File: rtl/cr_toggle_detect.sv
module cr_toggle_detect
  import cr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] cr0_q,
  input  logic [DATA_W-1:0] cr4_q,
  input  logic [DATA_W-1:0] efer_q,
  input  logic [DATA_W-1:0] csattr_q,
  output logic              flush_all,
  output logic              flush_ng,
  output logic              recompute,
  output logic              lma_we,
  output logic              lma_val,
  output logic              cs_lm_set,
  output logic              cs_lm_clr
);
  logic hit_cr0, hit_cr3, hit_cr4, hit_cs, hit_ss;
  logic [DATA_W-1:0] diff_cr0, diff_cr4, diff_cs;

  always_comb begin
    hit_cr0  = wr_en && (wr_addr == ADDR_W'(A_CR0));
    hit_cr3  = wr_en && (wr_addr == ADDR_W'(A_CR3));
    hit_cr4  = wr_en && (wr_addr == ADDR_W'(A_CR4));
    hit_cs   = wr_en && (wr_addr == ADDR_W'(A_CSATTR));
    hit_ss   = wr_en && (wr_addr == ADDR_W'(A_SSATTR));

    diff_cr0 = cr0_q ^ wr_data;
    diff_cr4 = cr4_q ^ wr_data;
    diff_cs  = csattr_q ^ wr_data;

    flush_all = (hit_cr0 && diff_cr0[B_PG]) ||
                (hit_cr4 && (diff_cr4[B_PSE] || diff_cr4[B_PAE] || diff_cr4[B_PGE]));
    flush_ng  = hit_cr3;
    recompute = hit_cr0 || hit_cs || hit_ss;

    lma_we    = hit_cr0 && diff_cr0[B_PG] && efer_q[B_LME];
    lma_val   = wr_data[B_PG];

    cs_lm_set = hit_cs && diff_cs[B_CS_LM] &&  wr_data[B_CS_LM];
    cs_lm_clr = hit_cs && diff_cs[B_CS_LM] && !wr_data[B_CS_LM];
  end
endmodule

// File: rtl/seg_base_file.sv
module seg_base_file #(
  parameter int DATA_W     = 64,
  parameter int NUM_SEG    = 8,
  parameter int NUM_LEGACY = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SEG-1:0]              base_we,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            flat_mode,
  input  logic                            cs_lm_set,
  input  logic                            cs_lm_clr,
  output logic [NUM_SEG-1:0][DATA_W-1:0]  base_q,
  output logic [NUM_SEG-1:0][DATA_W-1:0]  eff_q
);
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [DATA_W-1:0] base_d, eff_d;
    logic              base_en, eff_en;

    always_comb begin
      base_en = base_we[g];
      base_d  = wr_data;
    end

    if (g < NUM_LEGACY) begin : g_legacy
      // Ignored in 64-bit code; rebuilt when the code-segment flag flips
      always_comb begin
        eff_en = 1'b0;
        eff_d  = eff_q[g];
        if (cs_lm_set) begin
          eff_en = 1'b1;
          eff_d  = '0;
        end else if (cs_lm_clr) begin
          eff_en = 1'b1;
          eff_d  = base_q[g];
        end else if (base_we[g] && !flat_mode) begin
          eff_en = 1'b1;
          eff_d  = wr_data;
        end
      end
    end else begin : g_always
      always_comb begin
        eff_en = base_we[g];
        eff_d  = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        eff_q[g]  <= '0;
      end else begin
        if (base_en) base_q[g] <= base_d;
        if (eff_en)  eff_q[g]  <= eff_d;
      end
    end
  end
endmodule

// File: rtl/cr_side_effect_unit.sv
module cr_side_effect_unit
  import cr_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 5,
  parameter int NUM_SEG    = 8,
  parameter int NUM_LEGACY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              itlb_flush_all,
  output logic              itlb_flush_nonglobal,
  output logic              dtlb_flush_all,
  output logic              dtlb_flush_nonglobal,
  output logic              mode_recompute,
  output logic              efer_lma
);
  localparam int SEG_IDX_W = $clog2(NUM_SEG);
  localparam logic [DATA_W-1:0] CR0_RST = DATA_W'(1) << B_ET;

  logic [DATA_W-1:0] cr0_q, cr3_q, cr4_q, efer_q, csattr_q, ssattr_q;
  logic [DATA_W-1:0] cr0_d, efer_d;
  logic              cr0_en, cr3_en, cr4_en, efer_en, cs_en, ss_en;
  logic              flush_all, flush_ng, recompute, lma_we, lma_val;
  logic              cs_lm_set, cs_lm_clr;
  logic              fa_q, ng_q, rc_q;
  logic [NUM_SEG-1:0]             base_we;
  logic [NUM_SEG-1:0][DATA_W-1:0] base_q, eff_q;

  cr_toggle_detect #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_detect (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cr0_q     (cr0_q),
    .cr4_q     (cr4_q),
    .efer_q    (efer_q),
    .csattr_q  (csattr_q),
    .flush_all (flush_all),
    .flush_ng  (flush_ng),
    .recompute (recompute),
    .lma_we    (lma_we),
    .lma_val   (lma_val),
    .cs_lm_set (cs_lm_set),
    .cs_lm_clr (cs_lm_clr)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_bwe
    assign base_we[g] = wr_en && (wr_addr == ADDR_W'(A_BASE0 + g));
  end

  seg_base_file #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG), .NUM_LEGACY(NUM_LEGACY)) u_segs (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_we   (base_we),
    .wr_data   (wr_data),
    .flat_mode (efer_q[B_LMA] && csattr_q[B_CS_LM]),
    .cs_lm_set (cs_lm_set),
    .cs_lm_clr (cs_lm_clr),
    .base_q    (base_q),
    .eff_q     (eff_q)
  );

  // Next-state logic for the control words
  always_comb begin
    cr0_en  = wr_en && (wr_addr == ADDR_W'(A_CR0));
    cr3_en  = wr_en && (wr_addr == ADDR_W'(A_CR3));
    cr4_en  = wr_en && (wr_addr == ADDR_W'(A_CR4));
    cs_en   = wr_en && (wr_addr == ADDR_W'(A_CSATTR));
    ss_en   = wr_en && (wr_addr == ADDR_W'(A_SSATTR));
    cr0_d   = wr_data | CR0_RST;
    efer_en = 1'b0;
    efer_d  = efer_q;
    if (wr_en && (wr_addr == ADDR_W'(A_EFER))) begin
      efer_en = 1'b1;
      efer_d  = wr_data;
    end else if (lma_we) begin
      efer_en = 1'b1;
      efer_d[B_LMA] = lma_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_q    <= CR0_RST;
      cr3_q    <= '0;
      cr4_q    <= '0;
      efer_q   <= '0;
      csattr_q <= '0;
      ssattr_q <= '0;
      fa_q     <= 1'b0;
      ng_q     <= 1'b0;
      rc_q     <= 1'b0;
    end else begin
      if (cr0_en)  cr0_q    <= cr0_d;
      if (cr3_en)  cr3_q    <= wr_data;
      if (cr4_en)  cr4_q    <= wr_data;
      if (efer_en) efer_q   <= efer_d;
      if (cs_en)   csattr_q <= wr_data;
      if (ss_en)   ssattr_q <= wr_data;
      fa_q <= flush_all;
      ng_q <= flush_ng;
      rc_q <= recompute;
    end
  end

  // Read port
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_CR0))         rd_data = cr0_q;
    else if (rd_addr == ADDR_W'(A_CR3))    rd_data = cr3_q;
    else if (rd_addr == ADDR_W'(A_CR4))    rd_data = cr4_q;
    else if (rd_addr == ADDR_W'(A_EFER))   rd_data = efer_q;
    else if (rd_addr == ADDR_W'(A_CSATTR)) rd_data = csattr_q;
    else if (rd_addr == ADDR_W'(A_SSATTR)) rd_data = ssattr_q;
    else if (rd_addr >= ADDR_W'(A_BASE0) && rd_addr < ADDR_W'(A_BASE0 + NUM_SEG))
      rd_data = base_q[SEG_IDX_W'(rd_addr - ADDR_W'(A_BASE0))];
    else if (rd_addr >= ADDR_W'(A_EFF0) && rd_addr < ADDR_W'(A_EFF0 + NUM_SEG))
      rd_data = eff_q[SEG_IDX_W'(rd_addr - ADDR_W'(A_EFF0))];
  end

  assign itlb_flush_all       = fa_q;
  assign dtlb_flush_all       = fa_q;
  assign itlb_flush_nonglobal = ng_q;
  assign dtlb_flush_nonglobal = ng_q;
  assign mode_recompute       = rc_q;
  assign efer_lma             = efer_q[B_LMA];
endmodule

// File: rtl/cr_side_effect_unit_chk.sv
module cr_side_effect_unit_chk
  import cr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              itlb_flush_all,
  input logic              itlb_flush_nonglobal,
  input logic              dtlb_flush_nonglobal,
  input logic              mode_recompute,
  input logic              efer_lma
);
  p_cr3_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(A_CR3)) |=> (itlb_flush_nonglobal && dtlb_flush_nonglobal));

  p_flush_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    itlb_flush_all |-> $past(wr_en && (wr_addr == ADDR_W'(A_CR0) || wr_addr == ADDR_W'(A_CR4))));

  p_et_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(A_CR0)) |-> rd_data[B_ET]);

  p_recompute_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_recompute |-> $past(wr_en && (wr_addr == ADDR_W'(A_CR0) ||
                                       wr_addr == ADDR_W'(A_CSATTR) ||
                                       wr_addr == ADDR_W'(A_SSATTR))));

  p_lma_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(efer_lma) |-> $past(wr_en && (wr_addr == ADDR_W'(A_CR0) || wr_addr == ADDR_W'(A_EFER))));
endmodule

bind cr_side_effect_unit cr_side_effect_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk                  (clk),
  .rst_n                (rst_n),
  .wr_en                (wr_en),
  .wr_addr              (wr_addr),
  .rd_addr              (rd_addr),
  .rd_data              (rd_data),
  .itlb_flush_all       (itlb_flush_all),
  .itlb_flush_nonglobal (itlb_flush_nonglobal),
  .dtlb_flush_nonglobal (dtlb_flush_nonglobal),
  .mode_recompute       (mode_recompute),
  .efer_lma             (efer_lma)
);

// File: tb/cr_side_effect_unit_bench.sv
module cr_side_effect_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [63:0] wr_data;
  logic [4:0]  rd_addr;
  logic [63:0] rd_data;
  logic itlb_fa, itlb_ng, dtlb_fa, dtlb_ng, mode_rc, lma;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // Behavioural reference state
  logic [63:0] m_reg [0:31];
  bit exp_fa, exp_ng, exp_rc;

  always #5 clk = ~clk;

  cr_side_effect_unit u_cr_side_effect_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .itlb_flush_all(itlb_fa), .itlb_flush_nonglobal(itlb_ng),
    .dtlb_flush_all(dtlb_fa), .dtlb_flush_nonglobal(dtlb_ng),
    .mode_recompute(mode_rc), .efer_lma(lma));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t rd_addr=%0d)", req, act, exp, $time, rd_addr);
    end
  endtask

  function automatic string req_of(int a);
    if (a == 0) return "R5";
    if (a == 3) return "R1";
    if (a >= 16 && a <= 19) return "R6/R8";
    if (a >= 20 && a <= 23) return "R7";
    return "R10";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_reg[i] = 64'h0;
    m_reg[0] = 64'h10;
    exp_fa = 0; exp_ng = 0; exp_rc = 0;
  endtask

  // Reference model update and per-clock comparison
  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      logic [63:0] d, t;
      int a;
      exp_fa = 0; exp_ng = 0; exp_rc = 0;
      if (wr_en) begin
        a = int'(wr_addr);
        d = wr_data;
        if (a == 0) begin
          t = m_reg[0] ^ d;
          if (t[31]) exp_fa = 1;
          if (t[31] && m_reg[3][8]) m_reg[3][10] = d[31];
          m_reg[0] = d | 64'h10;
          exp_rc = 1;
        end else if (a == 1) begin
          m_reg[1] = d; exp_ng = 1;
        end else if (a == 2) begin
          t = m_reg[2] ^ d;
          if (t[4] || t[5] || t[7]) exp_fa = 1;
          m_reg[2] = d;
        end else if (a == 3) begin
          m_reg[3] = d;
        end else if (a == 4) begin
          if (m_reg[4][0] != d[0])
            for (int i = 0; i < 4; i++) m_reg[16+i] = d[0] ? 64'h0 : m_reg[8+i];
          m_reg[4] = d; exp_rc = 1;
        end else if (a == 5) begin
          m_reg[5] = d; exp_rc = 1;
        end else if (a >= 8 && a <= 15) begin
          if (a >= 12 || !(m_reg[3][10] && m_reg[4][0])) m_reg[a+8] = d;
          m_reg[a] = d;
        end
      end
      #2;
      check("R2/R4 itlb flush-all", 64'(itlb_fa), 64'(exp_fa));
      check("R2/R4 dtlb flush-all", 64'(dtlb_fa), 64'(exp_fa));
      check("R3 itlb flush-nonglobal", 64'(itlb_ng), 64'(exp_ng));
      check("R3 dtlb flush-nonglobal", 64'(dtlb_ng), 64'(exp_ng));
      check("R9 mode recompute", 64'(mode_rc), 64'(exp_rc));
      check("R1 efer_lma", 64'(lma), 64'(m_reg[3][10]));
      check(req_of(int'(rd_addr)), rd_data, m_reg[rd_addr]);
    end
  end

  // Read address sweeps every cycle
  initial begin
    rd_addr = 0;
    forever begin
      @(negedge clk);
      rd_addr = rd_addr + 5'd1;
    end
  end

  task automatic wr(int a, logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(34);                              // R10 reset values swept on the read port
    wr(0, 64'h8000_0001);                  // R2: PG on without LME, no LMA
    wr(0, 64'h8000_0003);                  // R2: PG unchanged, no flush
    wr(3, 64'h100);                        // set LME
    wr(0, 64'h0000_0001);                  // R1: PG off with LME
    wr(0, 64'h8000_0001);                  // R1: PG on with LME -> LMA
    wr(1, 64'h1000);                       // R3
    wr(1, 64'h1000);                       // R3: same value still flushes
    wr(2, 64'h20);                         // R4: PAE
    wr(2, 64'h28);                         // R4: bit 3 only, no flush
    wr(2, 64'h0);                          // R4
    for (int i = 0; i < 8; i++) wr(8 + i, 64'hA000 + 64'(i)); // R7, R8 legacy mode
    wr(4, 64'h1);                          // R6: 64-bit code, zero eff bases
    wr(8, 64'hBEEF);                       // R8: blocked
    wr(11, 64'hCAFE);                      // R8: blocked
    wr(13, 64'h5555);                      // R7: always copies
    wr(4, 64'h3);                          // R6: flag unchanged
    wr(16, 64'hDEAD);                      // R10: read-only address
    wr(30, 64'hDEAD);                      // R10: unused address
    wr(5, 64'h40);                         // R9
    idle(30);
    wr(4, 64'h2);                          // R6: reload from stored
    wr(0, 64'h1);                          // R1: PG off -> LMA clear
    wr(4, 64'h1);                          // R6, LMA clear
    wr(9, 64'h7777);                       // R8: LMA clear, allowed
    idle(34);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule